// File: doc/BRIEF.md
# Prescaled Reloading Tick Timer

This block is one timer channel that raises a periodic tick interrupt. The peripheral clock passes through a selectable prescaler. The prescaler steps a down-counter. When that counter steps below zero, it reloads itself from a constant register. Each reload sets a sticky underflow flag. The interrupt line is high while that flag and its enable are both set.

Software reaches the block through a simple synchronous port. A write lands on the clock edge. A read returns, in the same cycle, the register that the two-bit address selects. Software sets the period by writing the constant register. It then picks a prescale value and sets the run bit. In the interrupt handler it clears the flag by writing the control register back with the flag bit at zero.

Top module: `tick_timer`

## Requirements
- R1: After reset, all four registers read zero, the timer is halted and `irq` is low.
- R2: Bit 0 of the run register (address 0) starts the count when 1 and halts it when 0. While halted, the count keeps its value. The other bits of a write are ignored and read back as zero.
- R3: While running, the counter steps once every 4 << (2 * sel) clocks, where sel is control bits [2:0]. This gives 4, 16, 64 and 256 for sel 0 to 3. The first step comes exactly that many clocks after the edge that sets the run bit, because starting clears the prescaler.
- R4: A step from a count of 0 loads the value of the constant register (address 1). The tick period is therefore constant+1 prescaled steps.
- R5: The step that reloads the counter sets the underflow flag, control bit 8, in the same cycle.
- R6: A control write with bit 8 at 0 clears the flag. A control write with bit 8 at 1 leaves the flag unchanged, whether the flag was set or clear.
- R7: If a reload and a flag-clearing control write fall in the same cycle, the flag ends up set.
- R8: `irq` is a register that takes the AND of the flag and the interrupt enable (control bit 5). It therefore follows the flag and the enable one clock later.
- R9: Writes to the constant register and to the counter register (address 2) take effect at the next edge. A counter write takes priority over a prescaler step in the same cycle, and that step causes no reload.
- R10: The control register (address 3) reads back sel in bits [2:0], the enable in bit 5 and the flag in bit 8. All other bits read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe for the addressed register |
| addr | input | 2 | Register select: 0 run, 1 constant, 2 counter, 3 control |
| wdata | input | CNT_W | Write data |
| rdata | output | CNT_W | Read data of the addressed register, combinational |
| irq | output | 1 | Level interrupt: registered flag AND enable |

## Verification
A wrong prescaler phase or a wrong divide ratio shows up on the counter read within one prescale period: the count steps one clock early or late. A wrong reload value or a missed reload shows up at the first step after the count reaches zero. A flag that is lost or set falsely shows up in the control read in the same cycle. It shows up on `irq` one clock later when the enable is set. The bench keeps a behavioural model of these registers and compares the addressed read value and `irq` on every clock. Any such divergence is therefore reported in the cycle where it first becomes visible at the ports.

// File: rtl/tick_timer.sv
module tick_timer #(
  parameter int CNT_W = 32,
  parameter int PRE_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       addr,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] rdata,
  output logic             irq
);
  localparam logic [1:0] A_RUN = 2'd0;
  localparam logic [1:0] A_CST = 2'd1;
  localparam logic [1:0] A_CNT = 2'd2;
  localparam logic [1:0] A_CTL = 2'd3;
  localparam int CTL_W    = 16;
  localparam int FLAG_BIT = 8;
  localparam int IE_BIT   = 5;

  logic             run, ie, flag;
  logic [2:0]       sel;
  logic [CNT_W-1:0] reload, count;
  logic [PRE_W-1:0] pre, pre_top;
  logic [31:0]      div_full;
  logic             tick, wr_cnt, wr_ctl, underflow;
  logic [CTL_W-1:0] ctl_rd;

  assign wr_cnt    = wr_en && addr == A_CNT;
  assign wr_ctl    = wr_en && addr == A_CTL;
  assign div_full  = 32'd4 << {sel, 1'b0};
  assign pre_top   = PRE_W'(div_full - 32'd1);
  assign tick      = run && (pre >= pre_top);
  assign underflow = tick && !wr_cnt && count == '0;
  assign ctl_rd    = {7'b0, flag, 2'b0, ie, 2'b0, sel};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pre <= '0;
    else if (!run) pre <= '0;
    else if (tick) pre <= '0;
    else           pre <= pre + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run    <= 1'b0;
      reload <= '0;
    end else if (wr_en) begin
      if (addr == A_RUN) run    <= wdata[0];
      if (addr == A_CST) reload <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          count <= '0;
    else if (wr_cnt)     count <= wdata;
    else if (underflow)  count <= reload;
    else if (tick)       count <= count - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel  <= '0;
      ie   <= 1'b0;
      flag <= 1'b0;
      irq  <= 1'b0;
    end else begin
      if (wr_ctl) begin
        sel <= wdata[2:0];
        ie  <= wdata[IE_BIT];
      end
      if (underflow)                    flag <= 1'b1;
      else if (wr_ctl && !wdata[FLAG_BIT]) flag <= 1'b0;
      irq <= flag && ie;
    end
  end

  always_comb begin
    unique case (addr)
      A_RUN:   rdata = {{(CNT_W-1){1'b0}}, run};
      A_CST:   rdata = reload;
      A_CNT:   rdata = count;
      default: rdata = {{(CNT_W-CTL_W){1'b0}}, ctl_rd};
    endcase
  end
endmodule

module tick_timer_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [1:0]       addr,
  input logic [CNT_W-1:0] wdata,
  input logic             irq,
  input logic             run,
  input logic             ie,
  input logic             flag,
  input logic             tick,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] reload
);
  logic cnt_wr, ctl_clr;
  assign cnt_wr  = wr_en && addr == 2'd2;
  assign ctl_clr = wr_en && addr == 2'd3 && !wdata[8];

  p_halt_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !run && !cnt_wr |=> $stable(count));

  p_tick_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

  p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_wr && count != '0 |=> (count == $past(count) || count == $past(count) - 1'b1));

  p_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_wr && tick && count == '0 |=> flag && count == $past(reload));

  p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    flag && !ctl_clr |=> flag);

  p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_clr && tick && !cnt_wr && count == '0 |=> flag);

  p_irq_enable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(ie) && $past(flag));

  p_cnt_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> count == $past(wdata));
endmodule

bind tick_timer tick_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .irq(irq), .run(run), .ie(ie), .flag(flag), .tick(tick),
  .count(count), .reload(reload)
);

// File: tb/tick_timer_test.sv
module tick_timer_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  always #(CLK_PERIOD/2) clk = ~clk;

  tick_timer uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  int    checks = 0;
  int    errors = 0;
  string phase = "R1";
  bit    done = 0;

  bit          m_run = 0, m_ie = 0, m_flag = 0, m_irq = 0;
  logic [31:0] m_reload = '0, m_cnt = '0;
  int          m_sel = 0, m_pre = 0;

  function automatic logic [31:0] m_read(int a);
    case (a)
      0:       return {31'b0, m_run};
      1:       return m_reload;
      2:       return m_cnt;
      default: return 32'(m_sel) | (m_ie ? 32'h20 : 32'h0) | (m_flag ? 32'h100 : 32'h0);
    endcase
  endfunction

  task automatic check(string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %h expected %h", phase, what, act, exp);
    end
  endtask

  task automatic model_step(bit w, int a, logic [31:0] d);
    int  div;
    bit  tk, unf, n_irq;
    div   = 4 << (2 * m_sel);
    tk    = m_run && (m_pre >= div - 1);
    unf   = tk && !(w && a == 2) && m_cnt == 0;
    n_irq = m_flag && m_ie;
    if (!m_run || tk) m_pre = 0;
    else              m_pre = m_pre + 1;
    if (w && a == 2)  m_cnt = d;
    else if (unf)     m_cnt = m_reload;
    else if (tk)      m_cnt = m_cnt - 1;
    if (unf)                       m_flag = 1;
    else if (w && a == 3 && !d[8]) m_flag = 0;
    if (w && a == 3) begin
      m_sel = int'(d[2:0]);
      m_ie  = d[5];
    end
    if (w && a == 1) m_reload = d;
    if (w && a == 0) m_run = d[0];
    m_irq = n_irq;
  endtask

  task automatic step(bit w, int a, logic [31:0] d);
    wr_en = w;
    addr  = a[1:0];
    wdata = d;
    #1;
    check("rdata", rdata, m_read(a));
    check("irq", {31'b0, irq}, {31'b0, m_irq});
    @(posedge clk);
    model_step(w, a, d);
    @(negedge clk);
  endtask

  task automatic idle(int n, int a);
    for (int i = 0; i < n; i++) step(0, a, '0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    phase = "R1";
    for (int a = 0; a < 4; a++) step(0, a, '0);

    phase = "R10";
    step(1, 3, 32'hFFFF_FFFF);
    idle(2, 3);
    step(1, 3, 32'h0);
    idle(1, 3);

    phase = "R9";
    step(1, 1, 32'd5);
    step(1, 2, 32'd3);
    idle(1, 1);
    idle(1, 2);

    phase = "R3";
    step(1, 0, 32'd1);
    idle(40, 2);

    phase = "R5";
    idle(10, 3);

    phase = "R8";
    step(1, 3, 32'h0120);
    idle(30, 3);

    phase = "R6";
    step(1, 3, 32'h0020);
    idle(3, 3);
    step(1, 3, 32'h0120);
    idle(5, 3);

    phase = "R7";
    step(1, 1, 32'd2);
    for (int i = 0; i < 40; i++) step(1, 3, 32'h0020);
    idle(4, 3);

    phase = "R2";
    step(1, 0, 32'd0);
    idle(20, 2);
    step(1, 0, 32'hFFFF_FFFE);
    idle(10, 2);
    idle(1, 0);
    step(1, 0, 32'd1);
    idle(15, 2);

    phase = "R4";
    step(1, 3, 32'h0001);
    step(1, 1, 32'd3);
    idle(150, 2);
    step(1, 3, 32'h0022);
    idle(300, 2);
    idle(300, 3);

    phase = "R9";
    step(1, 3, 32'h0020);
    for (int i = 0; i < 20; i++) step(1, 2, 32'd0);
    step(1, 2, 32'd7);
    idle(40, 2);
    idle(5, 3);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog %s run did not finish", phase);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule